// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Register Target

This block is a serial two-wire bus target that keeps a small bank of byte-wide configuration registers and hands the whole bank to surrounding logic as one parallel vector. A host reaches the bank only through indexed block transfers. Every transaction first carries a starting location. A write then carries a byte count and that many data bytes. A read switches direction with a repeated start and gets back a length byte, followed by register contents from the chosen location onward.

Clock and data come in as open-drain line levels. The target pulls the data line low through a separate drive-low output. Both line levels pass through a synchronizer into the system clock. Start, stop and clock edges are found on the synchronized levels. A start or a stop seen at any point cancels the transaction in progress. The location counter stays where it was, so a read can follow a location-setting write phase.

Top module: `i2c_idx_regfile`

## Requirements
- R1: After a synchronous reset the data line is released. Every register reads 0x00, except register 8, which reads the bank size (0x10 for 16 registers).
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte gets no acknowledge, and every byte after it is ignored until the next START.
- R3: In a write, the data bytes after the count byte are stored to consecutive locations, starting at the received location. Registers that are not written keep their values.
- R4: The target acknowledges the address byte, the location byte, the count byte and each data byte within the count, by holding the data line low during the ninth clock.
- R5: A data byte beyond the received count is not acknowledged and not stored.
- R6: After a repeated START and address 0xD3, the target first sends the content of register 8, then the registers starting at the stored location. Bits go out most significant first.
- R7: The target sends another byte each time the host acknowledges. After a host NACK it releases the data line and sends nothing more.
- R8: The location advances by one after each byte stored or sent, and wraps from 15 back to 0, for both writes and reads.
- R9: The target changes its drive on the data line only while the clock line is low.
- R10: A STOP ends the transaction, so no later byte is stored without a new START. A START in mid-transfer returns the target to the address phase.
- R11: Only the low four bits of the location byte select a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sdaLow | output | 1 | Pulls the data line low when high |
| cfgOut | output | 128 | Register bank, register i in bits [8i+7:8i] |

## Verification
The bench builds the block with its defaults: 16 registers, the length byte at location 8, the 7-bit address 0x69 and two synchronizer stages. With 16 registers, a four-byte burst starting at location 14 covers the wrap from 15 to 0 in both directions. A location byte of 0x23 shows that the high bits are dropped. Because the length register lies inside the bank, one write changes what every later read sends first. The bench holds each clock phase for sixteen system cycles, which is long against the three-cycle synchronizer path. The check that drive changes happen only while the clock is low is therefore a strict one.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;      // take one received bit
    logic loadIndex;    // received byte is the start location
    logic loadCount;    // received byte is the block length
    logic writeData;    // store received byte, advance location
    logic loadTxCount;  // put the length register into the transmit shifter
    logic loadTxData;   // put bank[location] into the shifter, advance location
    logic shiftTx;      // present the next transmit bit
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } busState_t;

  typedef enum logic [2:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_READ
  } phase_t;

endpackage

// File: rtl/i2c_idx_sync.sv
module i2c_idx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  // idle bus is high, so the pipes reset high
  always_ff @(posedge clk) begin
    if (rst) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl    = sclPipe[STAGES-1];
  assign sdaLvl    = sdaPipe[STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  // data edges only count while the clock sits high on both samples
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2c_idx_ctrl.sv
module i2c_idx_ctrl
  import i2c_idx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [7:0] rxNext,
  input  logic       remainZero,
  input  logic       txBit,
  output dpStrobe_t  stb,
  output logic       sdaLow
);

  busState_t state, stateN;
  phase_t    phase, phaseN;
  logic [2:0] bitCnt, bitCntN;
  logic ackPend, ackPendN;
  logic byteFull, byteFullN;
  logic hostAck, hostAckN;

  always_comb begin
    stb       = '0;
    stateN    = state;
    phaseN    = phase;
    bitCntN   = bitCnt;
    ackPendN  = ackPend;
    byteFullN = byteFull;
    hostAckN  = hostAck;
    if (startSeen) begin
      stateN    = ST_RX;
      phaseN    = PH_ADDR;
      bitCntN   = '0;
      ackPendN  = 1'b0;
      byteFullN = 1'b0;
    end else if (stopSeen) begin
      stateN    = ST_IDLE;
      byteFullN = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            bitCntN     = 3'(bitCnt + 3'd1);
            if (bitCnt == 3'd7) begin
              byteFullN = 1'b1;
              ackPendN  = 1'b0;
              case (phase)
                PH_ADDR: begin
                  if (rxNext == {DEV_ADDR, 1'b0}) begin
                    ackPendN = 1'b1;
                    phaseN   = PH_INDEX;
                  end else if (rxNext == {DEV_ADDR, 1'b1}) begin
                    ackPendN = 1'b1;
                    phaseN   = PH_READ;
                  end
                end
                PH_INDEX: begin
                  stb.loadIndex = 1'b1;
                  ackPendN      = 1'b1;
                  phaseN        = PH_COUNT;
                end
                PH_COUNT: begin
                  stb.loadCount = 1'b1;
                  ackPendN      = 1'b1;
                  phaseN        = PH_WDATA;
                end
                PH_WDATA: begin
                  if (!remainZero) begin
                    stb.writeData = 1'b1;
                    ackPendN      = 1'b1;
                  end
                end
                default: ;
              endcase
            end
          end else if (sclFall && byteFull) begin
            byteFullN = 1'b0;
            stateN    = ackPend ? ST_ACK : ST_IDLE;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (phase == PH_READ) begin
              stb.loadTxCount = 1'b1;
              stateN          = ST_TX;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              bitCntN = '0;
              stateN  = ST_TXACK;
            end else begin
              stb.shiftTx = 1'b1;
              bitCntN     = 3'(bitCnt + 3'd1);
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            hostAckN = ~sdaLvl;
          end else if (sclFall) begin
            if (hostAck) begin
              stb.loadTxData = 1'b1;
              stateN         = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitCnt   <= '0;
      ackPend  <= 1'b0;
      byteFull <= 1'b0;
      hostAck  <= 1'b0;
    end else begin
      state    <= stateN;
      phase    <= phaseN;
      bitCnt   <= bitCntN;
      ackPend  <= ackPendN;
      byteFull <= byteFullN;
      hostAck  <= hostAckN;
    end
  end

  assign sdaLow = (state == ST_ACK) | ((state == ST_TX) & ~txBit);

  // R9: the target only starts pulling the line low while the clock is low
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sdaLow) |-> !sclLvl);

  // R10: a stop releases the line on the next cycle
  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stopSeen |=> !sdaLow);

  // R2: a foreign address byte never arms an acknowledge
  p_foreign_addr_nack_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX && phase == PH_ADDR && sclRise && !startSeen && !stopSeen &&
     bitCnt == 3'd7 && rxNext[7:1] != DEV_ADDR) |=> !ackPend);

  // R4: an armed acknowledge reaches the line after the eighth falling edge
  p_ack_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX && byteFull && ackPend && sclFall && !startSeen && !stopSeen)
      |=> sdaLow);

endmodule

// File: rtl/i2c_idx_dp.sv
module i2c_idx_dp
  import i2c_idx_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int COUNT_REG = 8,
  localparam int IDXW     = $clog2(NUM_REGS),
  localparam int FLATW    = NUM_REGS * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdaLvl,
  input  dpStrobe_t        stb,
  output logic [7:0]       rxNext,
  output logic             remainZero,
  output logic             txBit,
  output logic [FLATW-1:0] bankFlat
);

  logic [6:0]      rxShift;
  logic [7:0]      txShift;
  logic [7:0]      remainQ;
  logic [IDXW-1:0] indexQ;
  logic [IDXW-1:0] idxInc;
  logic [7:0]      bankArr [NUM_REGS];

  assign rxNext     = {rxShift, sdaLvl};
  assign remainZero = (remainQ == 8'd0);
  assign txBit      = txShift[7];
  assign idxInc     = (indexQ == IDXW'(NUM_REGS - 1)) ? '0 : indexQ + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= '0;
      txShift <= '1;
      remainQ <= '0;
      indexQ  <= '0;
    end else begin
      if (stb.shiftIn)   rxShift <= rxNext[6:0];
      if (stb.loadIndex) indexQ  <= rxNext[IDXW-1:0];
      if (stb.loadCount) remainQ <= rxNext;
      if (stb.writeData) begin
        remainQ <= remainQ - 8'd1;
        indexQ  <= idxInc;
      end
      if (stb.loadTxCount) begin
        txShift <= bankArr[COUNT_REG];
      end else if (stb.loadTxData) begin
        txShift <= bankArr[indexQ];
        indexQ  <= idxInc;
      end else if (stb.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gCell
    localparam logic [7:0] RST_VAL = (g == COUNT_REG) ? 8'(NUM_REGS) : 8'h00;
    logic [7:0] cellQ;
    always_ff @(posedge clk) begin
      if (rst)                                         cellQ <= RST_VAL;
      else if (stb.writeData && indexQ == IDXW'(g))    cellQ <= rxNext;
    end
    assign bankArr[g]        = cellQ;
    assign bankFlat[g*8 +: 8] = cellQ;
  end

  // R5: no store once the received length is used up
  p_no_store_past_count_r5: assert property (@(posedge clk) disable iff (rst)
    stb.writeData |-> !remainZero);

  // R3: the bank only changes on a store strobe
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !stb.writeData |=> $stable(bankFlat));

  // R8: the location wraps from the last register to zero
  p_index_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ((stb.writeData || stb.loadTxData) && indexQ == IDXW'(NUM_REGS - 1))
      |=> indexQ == '0);

endmodule

// File: rtl/i2c_idx_regfile.sv
module i2c_idx_regfile #(
  parameter int         NUM_REGS    = 16,
  parameter int         COUNT_REG   = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaLow,
  output logic [NUM_REGS*8-1:0] cfgOut
);
  import i2c_idx_pkg::*;

  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic [7:0] rxNext;
  logic remainZero, txBit;
  dpStrobe_t stb;

  i2c_idx_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_idx_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rst(rst), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .rxNext(rxNext), .remainZero(remainZero),
    .txBit(txBit), .stb(stb), .sdaLow(sdaLow)
  );

  i2c_idx_dp #(.NUM_REGS(NUM_REGS), .COUNT_REG(COUNT_REG)) uDp (
    .clk(clk), .rst(rst), .sdaLvl(sdaLvl), .stb(stb),
    .rxNext(rxNext), .remainZero(remainZero), .txBit(txBit),
    .bankFlat(cfgOut)
  );

endmodule

// File: tb/i2c_idx_regfile_test.sv
module i2c_idx_regfile_test;

  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaLow;
  logic [127:0] cfgOut;
  wire sdaBus = mSda & ~sdaLow;

  int vectors = 0;
  int errors = 0;
  int driveGlitch = 0;
  logic prevLow = 1'b0;
  logic finished = 1'b0;
  logic [7:0] expBank [16];

  always #4 clk = ~clk;

  i2c_idx_regfile uut (
    .clk(clk), .rst(rst), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaLow(sdaLow), .cfgOut(cfgOut)
  );

  // R9 monitor: drive must hold still while the clock line is high
  always @(negedge clk) begin
    if (!rst && mScl && sdaLow !== prevLow) driveGlitch <= driveGlitch + 1;
    prevLow <= sdaLow;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] want);
    vectors++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, want);
    end
  endtask

  task automatic chkBank(input string tag);
    logic bad = 1'b0;
    vectors++;
    for (int i = 0; i < 16; i++) begin
      if (!bad && cfgOut[i*8 +: 8] !== expBank[i]) begin
        bad = 1'b1;
        errors++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, cfgOut[i*8 +: 8], expBank[i]);
      end
    end
  endtask

  task automatic busStart();
    if (!mScl) begin
      mSda = 1'b1; w(Q);
      mScl = 1'b1; w(Q);
    end
    mSda = 1'b0; w(Q);
    mScl = 1'b0; w(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; w(Q);
    mScl = 1'b1; w(Q);
    mSda = 1'b1; w(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; w(Q);
      mScl = 1'b1; w(2*Q);
      mScl = 1'b0; w(Q);
    end
    mSda = 1'b1; w(Q);
    mScl = 1'b1; w(Q);
    ack = ~sdaBus;
    w(Q);
    mScl = 1'b0; w(Q);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    b = '0;
    mSda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q);
      mScl = 1'b1; w(Q);
      b = {b[6:0], sdaBus};
      w(Q);
      mScl = 1'b0; w(Q);
    end
    mSda = ~giveAck; w(Q);
    mScl = 1'b1; w(2*Q);
    mScl = 1'b0; w(Q);
    mSda = 1'b1;
  endtask

  task automatic sendExpect(input string tag, input logic [7:0] b, input logic wantAck);
    logic a;
    sendByte(b, a);
    chk(tag, {7'd0, a}, {7'd0, wantAck});
  endtask

  task automatic tReset();
    chk("R1 release after reset", {7'd0, sdaLow}, 8'h00);
    chkBank("R1 reset bank");
  endtask

  task automatic tWriteBasic();
    busStart();
    sendExpect("R2 write address ack", 8'hD2, 1'b1);
    sendExpect("R4 location ack", 8'h02, 1'b1);
    sendExpect("R4 count ack", 8'h03, 1'b1);
    sendExpect("R3 data0 ack", 8'hA1, 1'b1);
    sendExpect("R3 data1 ack", 8'hB2, 1'b1);
    sendExpect("R3 data2 ack", 8'hC3, 1'b1);
    busStop();
    expBank[2] = 8'hA1; expBank[3] = 8'hB2; expBank[4] = 8'hC3;
    chkBank("R3 block write");
  endtask

  task automatic tBadAddr();
    busStart();
    sendExpect("R2 foreign address nack", 8'hA4, 1'b0);
    sendExpect("R2 ignored byte", 8'h00, 1'b0);
    sendExpect("R2 ignored byte", 8'h01, 1'b0);
    sendExpect("R2 ignored byte", 8'h5A, 1'b0);
    busStop();
    chkBank("R2 bank untouched");
  endtask

  task automatic tOverCount();
    busStart();
    sendExpect("R4 address", 8'hD2, 1'b1);
    sendExpect("R4 location", 8'h05, 1'b1);
    sendExpect("R4 count", 8'h01, 1'b1);
    sendExpect("R5 in-count data ack", 8'h11, 1'b1);
    sendExpect("R5 extra data nack", 8'h22, 1'b0);
    busStop();
    expBank[5] = 8'h11;
    chkBank("R5 extra byte discarded");
  endtask

  task automatic tWrapWrite();
    busStart();
    sendExpect("R8 address", 8'hD2, 1'b1);
    sendExpect("R8 location", 8'h0E, 1'b1);
    sendExpect("R8 count", 8'h04, 1'b1);
    for (int i = 0; i < 4; i++) sendExpect("R8 wrap data", 8'(8'h40 + i), 1'b1);
    busStop();
    expBank[14] = 8'h40; expBank[15] = 8'h41; expBank[0] = 8'h42; expBank[1] = 8'h43;
    chkBank("R8 write wraps 15 to 0");
  endtask

  task automatic tRead(input logic [7:0] loc, input int nData);
    logic [7:0] b;
    int idx = int'(loc[3:0]);
    busStart();
    sendExpect("R6 address", 8'hD2, 1'b1);
    sendExpect("R6 location", loc, 1'b1);
    busStart();
    sendExpect("R6 read address ack", 8'hD3, 1'b1);
    recvByte(1'b1, b);
    chk("R6 length byte first", b, expBank[8]);
    for (int i = 0; i < nData; i++) begin
      recvByte(i != nData - 1, b);
      chk("R8 read data in order", b, expBank[idx]);
      idx = (idx + 1) % 16;
    end
    w(Q);
    chk("R7 released after host nack", {7'd0, sdaLow}, 8'h00);
    busStop();
  endtask

  task automatic tLengthReg();
    busStart();
    sendExpect("R6 address", 8'hD2, 1'b1);
    sendExpect("R6 location 8", 8'h08, 1'b1);
    sendExpect("R6 count", 8'h01, 1'b1);
    sendExpect("R6 new length", 8'h03, 1'b1);
    busStop();
    expBank[8] = 8'h03;
    chkBank("R6 length register written");
    tRead(8'h02, 2);
  endtask

  task automatic tAbort();
    busStart();
    sendExpect("R10 address", 8'hD2, 1'b1);
    sendExpect("R10 location", 8'h0A, 1'b1);
    sendExpect("R10 count", 8'h03, 1'b1);
    sendExpect("R10 data", 8'h77, 1'b1);
    busStop();
    expBank[10] = 8'h77;
    chkBank("R10 stop ends block");
    busStart();
    sendExpect("R10 address", 8'hD2, 1'b1);
    sendExpect("R10 location", 8'h0C, 1'b1);
    sendExpect("R10 count", 8'h02, 1'b1);
    busStart();
    sendExpect("R10 restart goes to address", 8'hD2, 1'b1);
    sendExpect("R10 location", 8'h03, 1'b1);
    sendExpect("R10 count", 8'h01, 1'b1);
    sendExpect("R10 data", 8'h5C, 1'b1);
    busStop();
    expBank[3] = 8'h5C;
    chkBank("R10 restart abandons old block");
  endtask

  task automatic tIndexMask();
    busStart();
    sendExpect("R11 address", 8'hD2, 1'b1);
    sendExpect("R11 wide location", 8'h23, 1'b1);
    sendExpect("R11 count", 8'h01, 1'b1);
    sendExpect("R11 data", 8'hE7, 1'b1);
    busStop();
    expBank[3] = 8'hE7;
    chkBank("R11 high location bits dropped");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) expBank[i] = (i == 8) ? 8'h10 : 8'h00;
    w(10);
    rst = 1'b0;
    w(10);
    tReset();
    tWriteBasic();
    tBadAddr();
    tOverCount();
    tWrapWrite();
    tRead(8'h0E, 3);
    tLengthReg();
    tAbort();
    tIndexMask();
    chk("R9 drive stable while clock high", 8'(driveGlitch), 8'h00);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule